// File: doc/BRIEF.md
# Color Lookup Table RAM

This block is the color lookup table of a display controller. It holds 256 color entries of 16 bits each. Software loads them through 128 bus words of 32 bits. Each word carries two entries, so the table fills in half as many bus transfers as it has entries. The display pipeline reads the table through a separate port. It presents an 8-bit pixel index and gets back a 24-bit RGB color on the next clock.

An entry stores three 5-bit channels and one spare flag bit. The flag is kept in storage and comes back on bus reads, but it plays no part in the color. On lookup, each channel is widened to 8 bits by placing it in the upper bits and filling the lower three bits with zeros.

Bus reads return the stored word unchanged, one clock after the request. Decoding of the wider register space is done outside this block. It only sees a select, a write flag and a word index. The word index is the byte offset minus 0x200, shifted right by two, so word k sits at byte offset 0x200 + 4k.

Top module: `clut_ram`

## Requirements
- R1: A write to word k (bus_sel=1, bus_we=1, bus_widx=k) stores bits 15:0 as entry 2k and bits 31:16 as entry 2k+1.
- R2: For each 16-bit entry, red is taken from bits 4:0, green from bits 9:5 and blue from bits 14:10. These appear on pix_rgb[23:16], pix_rgb[15:8] and pix_rgb[7:0].
- R3: Each 5-bit channel is output as its value shifted left by three, so the low three bits of every output channel are zero.
- R4: Bit 15 of an entry has no effect on pix_rgb.
- R5: A read (bus_sel=1, bus_we=0, bus_widx=k) places on bus_rdata, one clock later, exactly the 32-bit value last written to word k. This includes both bit-15 flags.
- R6: bus_rdata changes only after a read cycle. It holds its value across idle cycles and write cycles.
- R7: pix_rgb shows the entry selected by pix_idx at the previous clock edge. A change of pix_idx does not reach pix_rgb before the next edge.
- R8: When a bus write and a pixel lookup hit the same word in the same cycle, the lookup returns the entry's value from before the write. The new value is seen on the next lookup.
- R9: While rst_n is low, bus_rdata and pix_rgb are zero.
- R10: bus_we with bus_sel low writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access to the table this cycle |
| bus_we | input | 1 | 1 = write, 0 = read (when selected) |
| bus_widx | input | 7 | Word index, byte offset bits 8:2 |
| bus_wdata | input | 32 | Write data, two packed entries |
| bus_rdata | output | 32 | Read data, valid one clock after a read |
| pix_idx | input | 8 | Pixel-side entry index |
| pix_rgb | output | 24 | Expanded color {R,G,B}, one clock after pix_idx |

## Verification
The bench builds the block with its default parameters: 128 words, 5-bit channels and 8-bit output channels. With these values the whole 8-bit index range can be reached, including both boundary words 0 and 127 and the top entries 254 and 255. It fills every word with a computed pattern that sets the flag bits in many entries. It then checks all 256 lookups and all 128 read-backs. Directed cycles cover same-word write/lookup collisions, unselected writes, read-data hold and one-cycle lookup latency.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int unsigned CLUT_WORDS_DEF = 128;
  localparam int unsigned CLUT_CH_W_DEF  = 5;
  localparam int unsigned CLUT_OUT_W_DEF = 8;
  localparam int unsigned CLUT_NUM_CH    = 3;
endpackage

// File: rtl/clut_bank.sv
module clut_bank #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Combinational reads; callers register the result, so a same-cycle
  // write is seen only after the edge (old value first).
  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/clut_expand.sv
module clut_expand
  import clut_pkg::*;
#(
  parameter int unsigned CH_W  = CLUT_CH_W_DEF,
  parameter int unsigned OUT_W = CLUT_OUT_W_DEF,
  localparam int unsigned ENT_W = CLUT_NUM_CH * CH_W + 1,
  localparam int unsigned RGB_W = CLUT_NUM_CH * OUT_W
) (
  input  logic [ENT_W-1:0] entry,
  output logic [RGB_W-1:0] rgb
);
  function automatic logic [OUT_W-1:0] widen(input logic [CH_W-1:0] v);
    widen = {v, {(OUT_W - CH_W){1'b0}}};
  endfunction

  // Flag bit is carried in storage only; it does not reach the color.
  logic unused_flag;
  assign unused_flag = entry[ENT_W-1];

  for (genvar c = 0; c < CLUT_NUM_CH; c++) begin : g_ch
    // channel 0 (red) lands in the top byte
    assign rgb[RGB_W-1-c*OUT_W -: OUT_W] = widen(entry[c*CH_W +: CH_W]);
  end
endmodule

// File: rtl/clut_ram.sv
module clut_ram
  import clut_pkg::*;
#(
  parameter int unsigned WORDS = CLUT_WORDS_DEF,
  parameter int unsigned CH_W  = CLUT_CH_W_DEF,
  parameter int unsigned OUT_W = CLUT_OUT_W_DEF,
  localparam int unsigned WIDX_W = $clog2(WORDS),
  localparam int unsigned PIDX_W = WIDX_W + 1,
  localparam int unsigned HALF_W = CLUT_NUM_CH * CH_W + 1,
  localparam int unsigned WORD_W = 2 * HALF_W,
  localparam int unsigned RGB_W  = CLUT_NUM_CH * OUT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [WIDX_W-1:0] bus_widx,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [PIDX_W-1:0] pix_idx,
  output logic [RGB_W-1:0]  pix_rgb
);
  // Named events for the logic and its assertions
  logic              wr_evt, rd_evt;
  logic [WIDX_W-1:0] pix_word;
  logic              pix_odd;
  assign wr_evt   = bus_sel & bus_we;
  assign rd_evt   = bus_sel & ~bus_we;
  assign pix_word = pix_idx[PIDX_W-1:1];
  assign pix_odd  = pix_idx[0];

  logic [HALF_W-1:0] bus_half [2];
  logic [HALF_W-1:0] pix_half [2];

  // Bank 0 holds even entries (low halfword), bank 1 odd entries.
  for (genvar h = 0; h < 2; h++) begin : g_bank
    clut_bank #(.DEPTH(WORDS), .WIDTH(HALF_W)) u_bank (
      .clk     (clk),
      .we      (wr_evt),
      .waddr   (bus_widx),
      .wdata   (bus_wdata[h*HALF_W +: HALF_W]),
      .raddr_a (bus_widx),
      .rdata_a (bus_half[h]),
      .raddr_b (pix_word),
      .rdata_b (pix_half[h])
    );
  end

  logic [WORD_W-1:0] rdata_q;
  logic [HALF_W-1:0] pix_ent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q   <= '0;
      pix_ent_q <= '0;
    end else begin
      if (rd_evt) rdata_q <= {bus_half[1], bus_half[0]};
      pix_ent_q <= pix_half[pix_odd];
    end
  end

  assign bus_rdata = rdata_q;

  clut_expand #(.CH_W(CH_W), .OUT_W(OUT_W)) u_expand (
    .entry (pix_ent_q),
    .rgb   (pix_rgb)
  );

  // ---------------------------------------------------------------
  // Assertion support: last bus write, tracked independently of banks
  // ---------------------------------------------------------------
  logic              lw_vld;
  logic [WIDX_W-1:0] lw_idx;
  logic [WORD_W-1:0] lw_data;
  logic [CH_W-1:0]   lw_red;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lw_vld  <= 1'b0;
      lw_idx  <= '0;
      lw_data <= '0;
    end else if (wr_evt) begin
      lw_vld  <= 1'b1;
      lw_idx  <= bus_widx;
      lw_data <= bus_wdata;
    end
  end

  assign lw_red = pix_odd ? lw_data[HALF_W +: CH_W] : lw_data[0 +: CH_W];

  // R5: read-back returns the value last written to that word
  a_r5_readback: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt && lw_vld && (bus_widx == lw_idx) |=> bus_rdata == $past(lw_data));

  // R6: read data holds when no read is made
  a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(bus_rdata));

  // R7: lookup of the last-written word shows its red channel next cycle
  a_r7_pixel_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt && lw_vld && (pix_word == lw_idx)
    |=> pix_rgb[RGB_W-1 -: CH_W] == $past(lw_red));

  // R8: same-word write and lookup return the pre-write entry
  a_r8_old_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && lw_vld && (bus_widx == lw_idx) && (pix_word == lw_idx)
    |=> pix_rgb[RGB_W-1 -: CH_W] == $past(lw_red));

  // R3: low bits of every output channel are zero
  a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pix_rgb[OUT_W-CH_W-1:0] == '0) &&
             (pix_rgb[2*OUT_W-CH_W-1:OUT_W] == '0) &&
             (pix_rgb[3*OUT_W-CH_W-1:2*OUT_W] == '0));
endmodule

// File: tb/clut_ram_bench.sv
`timescale 1ns/1ps
module clut_ram_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_widx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  clut_ram u_clut_ram (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  // Stimulus table: {word index, data}
  localparam logic [38:0] VEC [8] = '{
    {7'd0,   32'hFFFF_0000},
    {7'd127, 32'h7C1F_83E0},
    {7'd1,   32'h8000_7FFF},
    {7'd64,  32'h001F_03E0},
    {7'd2,   32'h7C00_8421},
    {7'd126, 32'h5294_AD6B},
    {7'd33,  32'h1234_FEDC},
    {7'd90,  32'hC631_39CE}
  };

  // Expected color: each 5-bit channel times eight, R high, B low
  function automatic logic [23:0] exp_rgb(input logic [15:0] e);
    logic [7:0] r, g, b;
    r = 8'(e[4:0]) * 8'd8;
    g = 8'(e[9:5]) * 8'd8;
    b = 8'(e[14:10]) * 8'd8;
    return {r, g, b};
  endfunction

  function automatic logic [31:0] pattern(input int k);
    return (32'(k) * 32'h0101_0203) ^ 32'hA5C3_9E1F;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [6:0] k, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_widx = k; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read_chk(input logic [6:0] k, input logic [31:0] exp,
                              input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_widx = k;
    @(negedge clk);
    bus_sel = 1'b0;
    check(bus_rdata, exp, tag);
  endtask

  task automatic pix_chk(input logic [7:0] i, input logic [23:0] exp,
                         input string tag);
    @(negedge clk);
    pix_idx = i;
    @(negedge clk);
    check({8'h0, pix_rgb}, {8'h0, exp}, tag);
  endtask

  initial begin
    logic [31:0] held;
    // R9: reset state
    repeat (3) @(negedge clk);
    check(bus_rdata, 32'h0, "R9 rdata in reset");
    check({8'h0, pix_rgb}, 32'h0, "R9 pix_rgb in reset");
    rst_n = 1'b1;

    // Table walk: R1, R2, R3, R4, R5
    for (int v = 0; v < 8; v++) bus_write(VEC[v][38:32], VEC[v][31:0]);
    for (int v = 0; v < 8; v++) begin
      bus_read_chk(VEC[v][38:32], VEC[v][31:0], "R5 table readback");
      pix_chk({VEC[v][38:32], 1'b0}, exp_rgb(VEC[v][15:0]), "R1 R2 R4 even entry");
      pix_chk({VEC[v][38:32], 1'b1}, exp_rgb(VEC[v][31:16]), "R1 R2 R3 odd entry");
    end

    // Full load of all words, then every entry and every word
    for (int k = 0; k < 128; k++) bus_write(7'(k), pattern(k));
    for (int k = 0; k < 128; k++) begin
      bus_read_chk(7'(k), pattern(k), "R5 full readback");
      pix_chk(8'(2*k), exp_rgb(pattern(k)[15:0]), "R1 R4 full even");
      pix_chk(8'(2*k+1), exp_rgb(pattern(k)[31:16]), "R1 R4 full odd");
    end

    // R8: collision on even entry 20 and odd entry 21 (word 10)
    bus_write(7'd10, 32'h1111_2222);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_widx = 7'd10; bus_wdata = 32'h3333_4444;
    pix_idx = 8'd20;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    check({8'h0, pix_rgb}, {8'h0, exp_rgb(16'h2222)}, "R8 old value even");
    @(negedge clk);
    check({8'h0, pix_rgb}, {8'h0, exp_rgb(16'h4444)}, "R8 new value next lookup");
    bus_sel = 1'b1; bus_we = 1'b1; bus_widx = 7'd10; bus_wdata = 32'h5555_6666;
    pix_idx = 8'd21;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    check({8'h0, pix_rgb}, {8'h0, exp_rgb(16'h3333)}, "R8 old value odd");

    // R10: unselected write leaves word 10 unchanged
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b1; bus_widx = 7'd10; bus_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    bus_we = 1'b0;
    bus_read_chk(7'd10, 32'h5555_6666, "R10 unselected write ignored");
    pix_chk(8'd20, exp_rgb(16'h6666), "R10 entry unchanged");

    // R6: rdata holds over idle and write cycles
    held = bus_rdata;
    repeat (3) @(negedge clk);
    check(bus_rdata, held, "R6 hold while idle");
    bus_write(7'd11, 32'h0F0F_F0F0);
    check(bus_rdata, held, "R6 hold across write");

    // R7: lookup latency is exactly one edge
    pix_chk(8'd0, exp_rgb(pattern(0)[15:0]), "R7 setup");
    @(negedge clk);
    pix_idx = 8'd255;
    #1;
    check({8'h0, pix_rgb}, {8'h0, exp_rgb(pattern(0)[15:0])}, "R7 no change before edge");
    @(negedge clk);
    check({8'h0, pix_rgb}, {8'h0, exp_rgb(pattern(127)[31:16])}, "R7 new entry after edge");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule